// File: doc/BRIEF.md
# Integer Multiply Stage with Overflow Flags

This block is the multiply stage of a 64-bit integer datapath. Each cycle it can accept one operation: two register operands, a high/low product select, a 32-bit width flag, a signed flag, an overflow-record request and the current sticky summary-overflow bit. Together the high/low select and the width flag give four operations:

- high word of a 32-bit product;
- high doubleword of a 64-bit product;
- low 64 bits of a 32-bit product;
- low 64 bits of a 64-bit product.

The stage is a two-register pipeline. The first register holds the conditioned operands. For signed forms these are the operand magnitudes plus a flag saying whether the two signs differ. The second register holds the formatted result, the two-bit overflow field and the passed-through summary-overflow bit. A result appears two clock edges after its operands.

Signed products are built from the operand magnitudes. The product is negated when the operand signs differ. Unsigned forms multiply the raw operand bits. On low-product operations that request it, the overflow flag reports whether the signed product fits in the destination width.

Top module: `mul_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first valid operation has passed the pipeline, `out_vld_o`, `ov_vld_o`, `so_vld_o`, `so_o`, `ov_o` and `res_o` are all zero.
- R2: An operation presented with `in_vld_i`=1 at a rising edge produces `out_vld_o`=1 with its results after the second following rising edge. A cycle with `in_vld_i`=0 produces `out_vld_o`=0, `ov_vld_o`=0 and `so_vld_o`=0 two edges later.
- R3: The signed high-doubleword form (`op_hi_i`=1, `w32_i`=0, `sgn_i`=1) returns bits 127..64 of the 128-bit two's-complement product of the operands.
- R4: The high-word form (`op_hi_i`=1, `w32_i`=1) multiplies the low 32 bits of each operand, sign-extended when `sgn_i`=1 and zero-extended otherwise. It places product bits 63..32 in both `res_o[63:32]` and `res_o[31:0]`.
- R5: The low-word form (`op_hi_i`=0, `w32_i`=1) returns the full 64-bit product of the low 32 bits of each operand, sign-extended when `sgn_i`=1 and zero-extended otherwise.
- R6: The low-doubleword form (`op_hi_i`=0, `w32_i`=0) returns bits 63..0 of the product and always treats the operands as signed. `sgn_i` has no effect on its result or its overflow flag.
- R7: For the low-word form, overflow is 1 when product bits 63..31 are neither all zero nor all one. The same value is driven on `ov_o[1]` (64-bit flag) and `ov_o[0]` (32-bit flag).
- R8: For the low-doubleword form, overflow is 1 when product bits 127..63 are neither all zero nor all one. It is driven on both bits of `ov_o`.
- R9: `ov_vld_o` is 1 only for a valid low-product operation that had `ov_en_i`=1. Whenever `ov_vld_o` is 0, `ov_o` is 2'b00. High-product forms never raise `ov_vld_o`.
- R10: For every valid operation, `so_o` equals the `so_i` value given with that operation and `so_vld_o` is 1.
- R11: The unsigned high-doubleword form (`op_hi_i`=1, `w32_i`=0, `sgn_i`=0) returns bits 127..64 of the product of the operands taken as unsigned 64-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld_i | input | 1 | Operation present this cycle |
| op_hi_i | input | 1 | 1 selects a high-product form, 0 a low-product form |
| w32_i | input | 1 | 1 selects a 32-bit form, 0 a 64-bit form |
| sgn_i | input | 1 | 1 treats the operands as signed |
| ov_en_i | input | 1 | Request recording of the overflow flag |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| so_i | input | 1 | Incoming summary-overflow bit |
| out_vld_o | output | 1 | Result valid |
| res_o | output | 64 | Result |
| ov_o | output | 2 | Overflow field: bit 1 is the 64-bit flag, bit 0 the 32-bit flag |
| ov_vld_o | output | 1 | Overflow field is to be recorded |
| so_o | output | 1 | Passed-through summary-overflow bit |
| so_vld_o | output | 1 | Summary-overflow output valid |

## Verification
The overflow flag and the summary-overflow pass-through leave the stage in the same output cycle. The risk is that one path corrupts or masks the other.

The bench provokes this by issuing back-to-back low-product operations with `ov_en_i` and `so_i` both high. Some of these overflow and some do not, including products of exactly -2^31 and 2^31 and the most negative 64-bit operands. Overflowing and non-overflowing operations alternate with high-product forms so that flag state cannot linger.

Every clock, both fields are compared against a wide-multiply reference queued two cycles earlier.

// File: rtl/mul_pkg.sv
package mul_pkg;

    typedef enum logic [1:0] {
        OP_HI32 = 2'd0,
        OP_HI64 = 2'd1,
        OP_LO32 = 2'd2,
        OP_LO64 = 2'd3
    } mul_op_e;

    function automatic mul_op_e decode_op(input logic hi, input logic w32);
        if (hi) return w32 ? OP_HI32 : OP_HI64;
        return w32 ? OP_LO32 : OP_LO64;
    endfunction

    function automatic logic is_low_op(input mul_op_e op);
        return (op == OP_LO32) || (op == OP_LO64);
    endfunction

endpackage

// File: rtl/mul_operand.sv
module mul_operand #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] opnd_i,
    input  logic            w32_i,
    input  logic            sgn_i,
    output logic [XLEN-1:0] mag_o,
    output logic            neg_o
);
    localparam int HALF = XLEN / 2;
    localparam logic [HALF-1:0] ONE_H = 1;
    localparam logic [XLEN-1:0] ONE_X = 1;

    logic [HALF-1:0] low_half;
    logic            sbit;

    assign low_half = opnd_i[HALF-1:0];
    assign sbit     = sgn_i & (w32_i ? opnd_i[HALF-1] : opnd_i[XLEN-1]);
    assign neg_o    = sbit;

    always_comb begin
        if (w32_i) begin
            mag_o = {{HALF{1'b0}}, (sbit ? (~low_half + ONE_H) : low_half)};
        end else begin
            mag_o = sbit ? (~opnd_i + ONE_X) : opnd_i;
        end
    end

endmodule

// File: rtl/mul_core.sv
module mul_core #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   mag_a_i,
    input  logic [XLEN-1:0]   mag_b_i,
    input  logic              neg_i,
    output logic [2*XLEN-1:0] prod_o
);
    localparam int PW = 2 * XLEN;
    localparam logic [PW-1:0] ONE_P = 1;

    logic [PW-1:0] umag;

    assign umag   = PW'(mag_a_i) * PW'(mag_b_i);
    assign prod_o = neg_i ? (~umag + ONE_P) : umag;

endmodule

// File: rtl/mul_format.sv
module mul_format
    import mul_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [2*XLEN-1:0] prod_i,
    input  mul_op_e           op_i,
    output logic [XLEN-1:0]   res_o,
    output logic              ov_o
);
    localparam int HALF = XLEN / 2;
    localparam int PW   = 2 * XLEN;

    logic [HALF:0] win_w;
    logic [XLEN:0] win_d;
    logic          ov_w;
    logic          ov_d;

    assign win_w = prod_i[XLEN-1:HALF-1];
    assign win_d = prod_i[PW-1:XLEN-1];
    assign ov_w  = (|win_w) & ~(&win_w);
    assign ov_d  = (|win_d) & ~(&win_d);

    always_comb begin
        unique case (op_i)
            OP_HI32: begin
                res_o = {2{prod_i[XLEN-1:HALF]}};
                ov_o  = 1'b0;
            end
            OP_HI64: begin
                res_o = prod_i[PW-1:XLEN];
                ov_o  = 1'b0;
            end
            OP_LO32: begin
                res_o = prod_i[XLEN-1:0];
                ov_o  = ov_w;
            end
            default: begin
                res_o = prod_i[XLEN-1:0];
                ov_o  = ov_d;
            end
        endcase
    end

endmodule

// File: rtl/mul_unit.sv
module mul_unit
    import mul_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld_i,
    input  logic            op_hi_i,
    input  logic            w32_i,
    input  logic            sgn_i,
    input  logic            ov_en_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            so_i,
    output logic            out_vld_o,
    output logic [XLEN-1:0] res_o,
    output logic [1:0]      ov_o,
    output logic            ov_vld_o,
    output logic            so_o,
    output logic            so_vld_o
);
    localparam int HALF = XLEN / 2;
    localparam int PW   = 2 * XLEN;

    // ---- stage 0: decode and operand conditioning ----
    mul_op_e         op_in;
    logic            sgn_eff;
    logic [XLEN-1:0] mag_a, mag_b;
    logic            neg_a, neg_b;

    assign op_in   = decode_op(op_hi_i, w32_i);
    // low doubleword is always a signed form
    assign sgn_eff = sgn_i | (op_in == OP_LO64);

    mul_operand #(.XLEN(XLEN)) u_opa (
        .opnd_i (a_i),
        .w32_i  (w32_i),
        .sgn_i  (sgn_eff),
        .mag_o  (mag_a),
        .neg_o  (neg_a)
    );

    mul_operand #(.XLEN(XLEN)) u_opb (
        .opnd_i (b_i),
        .w32_i  (w32_i),
        .sgn_i  (sgn_eff),
        .mag_o  (mag_b),
        .neg_o  (neg_b)
    );

    // ---- stage 1 register ----
    logic            s1_vld;
    mul_op_e         s1_op;
    logic [XLEN-1:0] s1_mag_a, s1_mag_b;
    logic            s1_neg;
    logic            s1_oven;
    logic            s1_so;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_op    <= OP_HI32;
            s1_mag_a <= '0;
            s1_mag_b <= '0;
            s1_neg   <= 1'b0;
            s1_oven  <= 1'b0;
            s1_so    <= 1'b0;
        end else begin
            s1_vld   <= in_vld_i;
            s1_op    <= op_in;
            s1_mag_a <= mag_a;
            s1_mag_b <= mag_b;
            s1_neg   <= neg_a ^ neg_b;
            s1_oven  <= ov_en_i;
            s1_so    <= so_i;
        end
    end

    // ---- stage 1 combinational: multiply, sign restore, format ----
    logic [PW-1:0]   prod;
    logic [XLEN-1:0] res_fmt;
    logic            ov_fmt;
    logic            rec_ov;

    mul_core #(.XLEN(XLEN)) u_core (
        .mag_a_i (s1_mag_a),
        .mag_b_i (s1_mag_b),
        .neg_i   (s1_neg),
        .prod_o  (prod)
    );

    mul_format #(.XLEN(XLEN)) u_fmt (
        .prod_i (prod),
        .op_i   (s1_op),
        .res_o  (res_fmt),
        .ov_o   (ov_fmt)
    );

    assign rec_ov = s1_vld & s1_oven & is_low_op(s1_op);

    // ---- stage 2 register (outputs) ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_o <= 1'b0;
            res_o     <= '0;
            ov_o      <= 2'b00;
            ov_vld_o  <= 1'b0;
            so_o      <= 1'b0;
            so_vld_o  <= 1'b0;
        end else begin
            out_vld_o <= s1_vld;
            res_o     <= s1_vld ? res_fmt : '0;
            ov_o      <= rec_ov ? {2{ov_fmt}} : 2'b00;
            ov_vld_o  <= rec_ov;
            so_o      <= s1_vld & s1_so;
            so_vld_o  <= s1_vld;
        end
    end

    // ---- assertions ----
    // R9
    ov_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_vld_o |-> (out_vld_o && $past(ov_en_i, 2) && !$past(op_hi_i, 2)));

    // R9
    ov_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ov_vld_o |-> (ov_o == 2'b00));

    // R7
    ov_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_o[1] == ov_o[0]);

    // R10
    so_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> (so_vld_o && so_o == $past(so_i, 2)));

    // R2
    vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_vld_i, 2) == out_vld_o);

    // R4
    hi32_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld_o && $past(op_hi_i && w32_i, 2)) |-> (res_o[XLEN-1:HALF] == res_o[HALF-1:0]));

endmodule

// File: tb/sim_mul_unit.sv
module sim_mul_unit;

    typedef struct {
        logic        vld;
        logic        hi;
        logic        w32;
        logic        sg;
        logic [63:0] res;
        logic        ovv;
        logic        ov;
        logic        so;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0, op_hi = 1'b0, w32 = 1'b0, sgn = 1'b0, ov_en = 1'b0, so_in = 1'b0;
    logic [63:0] a = '0, b = '0;
    logic        out_vld, ov_vld, so_out, so_vld;
    logic [63:0] res;
    logic [1:0]  ov;

    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    mul_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld_i  (in_vld),
        .op_hi_i   (op_hi),
        .w32_i     (w32),
        .sgn_i     (sgn),
        .ov_en_i   (ov_en),
        .a_i       (a),
        .b_i       (b),
        .so_i      (so_in),
        .out_vld_o (out_vld),
        .res_o     (res),
        .ov_o      (ov),
        .ov_vld_o  (ov_vld),
        .so_o      (so_out),
        .so_vld_o  (so_vld)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [63:0] x, input logic [63:0] y, input logic hi,
                                   input logic w, input logic sg, input logic oe,
                                   input logic so, input logic v);
        exp_t        e;
        logic [127:0] px, py, p;
        logic [32:0]  wn32;
        logic [64:0]  wn64;
        logic         sx;
        sx = sg | (!hi && !w);
        if (w) begin
            px = sx ? {{96{x[31]}}, x[31:0]} : {96'b0, x[31:0]};
            py = sx ? {{96{y[31]}}, y[31:0]} : {96'b0, y[31:0]};
        end else begin
            px = sx ? {{64{x[63]}}, x} : {64'b0, x};
            py = sx ? {{64{y[63]}}, y} : {64'b0, y};
        end
        p    = px * py;
        wn32 = p[63:31];
        wn64 = p[127:63];
        e.vld = v; e.hi = hi; e.w32 = w; e.sg = sg; e.so = so;
        if (hi) e.res = w ? {p[63:32], p[63:32]} : p[127:64];
        else    e.res = p[63:0];
        e.ov  = w ? !(wn32 == '0 || wn32 == '1) : !(wn64 == '0 || wn64 == '1);
        e.ovv = v & oe & !hi;
        return e;
    endfunction

    task automatic compare(input exp_t e);
        string tag;
        if (!e.vld) begin
            chk(!out_vld && !ov_vld && !so_vld, "R2 idle", {61'b0, out_vld, ov_vld, so_vld}, 64'd0);
            return;
        end
        chk(out_vld, "R2 valid", {63'b0, out_vld}, 64'd1);
        if (e.hi && e.w32)       tag = "R4 hi32";
        else if (e.hi && e.sg)   tag = "R3 hi64s";
        else if (e.hi)           tag = "R11 hi64u";
        else if (e.w32)          tag = "R5 lo32";
        else                     tag = "R6 lo64";
        chk(res === e.res, tag, res, e.res);
        chk(ov_vld === e.ovv, "R9 ov_vld", {63'b0, ov_vld}, {63'b0, e.ovv});
        if (e.ovv)
            chk(ov === {2{e.ov}}, e.w32 ? "R7 ov32" : "R8 ov64", {62'b0, ov}, {62'b0, e.ov, e.ov});
        else
            chk(ov === 2'b00, "R9 ov_zero", {62'b0, ov}, 64'd0);
        chk(so_out === e.so && so_vld, "R10 so", {62'b0, so_vld, so_out}, {62'b0, 1'b1, e.so});
    endtask

    // one clock: compare what is due, then present the next operation
    task automatic step(input logic v, input logic hi, input logic w, input logic sg,
                        input logic oe, input logic so, input logic [63:0] x, input logic [63:0] y);
        @(negedge clk);
        if (q.size() == 2) compare(q.pop_front());
        in_vld = v; op_hi = hi; w32 = w; sgn = sg; ov_en = oe; so_in = so; a = x; b = y;
        q.push_back(model(x, y, hi, w, sg, oe, so, v));
    endtask

    task automatic all_forms(input logic [63:0] x, input logic [63:0] y, input logic so);
        for (int k = 0; k < 8; k++)
            step(1'b1, k[2], k[1], k[0], 1'b1, so, x, y);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!out_vld && !ov_vld && !so_vld && !so_out && ov == 2'b00 && res == '0,
            "R1 reset", res, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_vld && !ov_vld && !so_vld && res == '0, "R1 after release", res, 64'd0);

        // corner cases, every form, summary overflow high and low
        all_forms(64'd0, 64'd12345, 1'b1);
        all_forms(64'h0000_0000_8000_0000, 64'd1, 1'b1);                 // -2^31 product
        all_forms(64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1); // 2^31 product
        all_forms(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
        all_forms(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        all_forms(64'h8000_0000_0000_0000, 64'd1, 1'b1);
        all_forms(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        all_forms(64'h0000_0000_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF, 1'b1);
        all_forms(64'h7FFF_FFFF_FFFF_FFFF, 64'd2, 1'b1);
        // overflow not requested, and a gap
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 64'h8000_0000, 64'hFFFF_FFFF);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 64'd7, 64'd9);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'd2);
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'd2);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [63:0] x, y;
            logic [31:0] r;
            r = $urandom;
            x = {$urandom, $urandom};
            y = {$urandom, $urandom};
            if (r[8])  x = x >> r[14:9];
            if (r[15]) y = y >> r[21:16];
            step(r[7] | r[6], r[0], r[1], r[2], r[3], r[4], x, y);
        end
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'd0, 64'd0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'd0, 64'd0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'd0, 64'd0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule